// File: doc/BRIEF.md
# Multi-Lane ADC Frame Deserialiser

This block receives conversion frames from a converter that does not use a standard serial peripheral port. The converter sends three kinds of signal: a data-ready strobe, a free-running data clock, and a small group of parallel data lines. The capture logic runs on the data clock. It aligns to the data-ready strobe and shifts each frame into a 96-bit register. It then hands the finished word to the system clock domain, together with a valid pulse that lasts one cycle.

A static mode input selects how the frame is laid out on the data lines. In serial mode all 96 bits arrive on data line 0. In wide mode the frame is split into three 32-bit slices that arrive at the same time on lines 0, 1 and 2. The number of lanes and the slice width are parameters. The frame width is derived from them.

If a new data-ready strobe arrives before the current frame is complete, the partial frame is discarded. The new strobe starts a fresh frame, and a sticky error flag is raised.

Top module: `adc_frame_rx`

## Requirements
- R1: While `rst_n` is low, `frame_valid` is 0, `frame_err` is 0 and `frame_data` is all zeros.
- R2: With `lane_mode` = 0 (serial), a frame is 96 consecutive bits on `dout[0]`. They arrive MSB first, so the first bit lands in `frame_data[95]` and the last bit in `frame_data[0]`.
- R3: With `lane_mode` = 1 (wide), a frame is 32 consecutive data-clock bits, each MSB first. The output word is {bits from `dout[0]`, bits from `dout[1]`, bits from `dout[2]`}, so `dout[0]` fills `frame_data[95:64]` and `dout[2]` fills `frame_data[31:0]`.
- R4: Data lines and `drdy` are sampled on the rising edge of `dclk`. A sample with `drdy` = 1 carries the first bit of a frame.
- R5: Data-line activity while no frame is in progress and `drdy` is 0 produces no `frame_valid` and does not alter the next frame.
- R6: A `drdy` sample that arrives while a frame is still incomplete discards the partial frame and starts a new frame with that sample. It also sets `frame_err`. The discarded frame is never delivered.
- R7: `frame_err` stays 1 once set, even across later clean frames, until `rst_n` is asserted.
- R8: Each completed frame produces exactly one `frame_valid` pulse of one `sys_clk` cycle. `frame_data` changes only in a cycle where `frame_valid` is 1 and holds its value in between.
- R9: In serial mode the values on `dout[2:1]` have no effect on the captured word.
- R10: A new `drdy` in the sample right after the last bit of a frame starts the next frame without raising `frame_err`, and both frames are delivered in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the output side |
| dclk | input | 1 | Data clock from the converter |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| lane_mode | input | 1 | 0 = serial on one line, 1 = split across lanes; change only between frames |
| drdy | input | 1 | Data-ready strobe, high with the first bit of a frame |
| dout | input | LANES (3) | Serial data lines; lane 0 is the serial-mode line |
| frame_data | output | 96 | Last completed frame, in the sys_clk domain |
| frame_valid | output | 1 | One-cycle pulse when frame_data is updated |
| frame_err | output | 1 | Sticky flag: a frame was cut short by an early data-ready |

## Verification
Serial frames use distinct, asymmetric words, which exposes reversed bit order or a slip of one bit, while random values on the unused lanes show those lanes are ignored. Wide frames are sent back to back with different words on every lane, which separates a swapped lane order from an off-by-one frame length and shows that a data-ready in the next sample is not counted as an abort. Aborted frames in both modes, followed by a clean frame, show that the partial data is dropped, that the new frame starts at the strobe, and that the error flag survives later good traffic. Idle stretches carrying random data with no strobe show that nothing is framed without data-ready.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;
   // How a frame is distributed over the data lines.
   typedef enum logic {
      LM_SERIAL = 1'b0,   // whole frame on lane 0
      LM_WIDE   = 1'b1    // one slice per lane, all lanes in parallel
   } lane_mode_e;

   localparam int unsigned DEF_LANES     = 3;
   localparam int unsigned DEF_LANE_BITS = 32;
endpackage

// File: rtl/adc_lane_shifter.sv
module adc_lane_shifter #(
   parameter int unsigned LANES     = 3,
   parameter int unsigned LANE_BITS = 32
) (
   input  logic                         dclk,
   input  logic                         rst_n,
   input  logic                         shift_en,
   input  logic                         wide,
   input  logic [LANES-1:0]             din,
   output logic [LANES*LANE_BITS-1:0]   word_d
);
   localparam int unsigned FRAME_BITS = LANES * LANE_BITS;

   logic [FRAME_BITS-1:0] word_q;

   // Each lane owns one slice. In wide mode a slice takes its own line;
   // in serial mode the slices form one chain fed from lane 0.
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int unsigned HI = FRAME_BITS - 1 - i * LANE_BITS;
      localparam int unsigned LO = HI - LANE_BITS + 1;
      logic chain_bit;
      logic in_bit;

      if (i == LANES - 1) begin : g_tail
         assign chain_bit = din[0];
      end else begin : g_link
         assign chain_bit = word_q[LO-1];
      end

      assign in_bit       = wide ? din[i] : chain_bit;
      assign word_d[HI:LO] = shift_en ? {word_q[HI-1:LO], in_bit} : word_q[HI:LO];
   end

   always_ff @(posedge dclk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
   end
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl #(
   parameter int unsigned FRAME_BITS = 96,
   parameter int unsigned LANE_BITS  = 32
) (
   input  logic dclk,
   input  logic rst_n,
   input  logic drdy,
   input  logic wide,
   output logic shift_en,
   output logic last,
   output logic err
);
   localparam int unsigned CW = $clog2(FRAME_BITS + 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last_idx;
   logic          active;
   logic          err_q;

   assign last_idx = wide ? CW'(LANE_BITS - 1) : CW'(FRAME_BITS - 1);
   assign active   = (cnt_q != '0);
   assign shift_en = drdy | active;
   assign last     = active & ~drdy & (cnt_q == last_idx);
   assign err      = err_q;

   always_ff @(posedge dclk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (drdy)   cnt_q <= CW'(1);
      else if (last)   cnt_q <= '0;
      else if (active) cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge dclk or negedge rst_n) begin
      if (!rst_n)              err_q <= 1'b0;
      else if (drdy && active) err_q <= 1'b1;
   end

   // R4 / R6: a strobe always restarts the bit count at one
   assert_restart_R6: assert property (@(posedge dclk) disable iff (!rst_n)
      drdy |=> (cnt_q == CW'(1)));

   // R6: a strobe inside a frame raises the error flag
   assert_abort_err_R6: assert property (@(posedge dclk) disable iff (!rst_n)
      (drdy && cnt_q != '0) |=> err_q);

   // R7: error flag never falls outside reset
   assert_err_sticky_R7: assert property (@(posedge dclk) disable iff (!rst_n)
      err_q |=> err_q);

   // R2 / R3: the counter stays inside the frame
   assert_cnt_bound_R2: assert property (@(posedge dclk) disable iff (!rst_n)
      cnt_q < CW'(FRAME_BITS));
endmodule

// File: rtl/adc_frame_cdc.sv
module adc_frame_cdc #(
   parameter int unsigned WIDTH = 96
) (
   input  logic             dclk,
   input  logic             sys_clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic [WIDTH-1:0] din,
   input  logic             err_in,
   output logic [WIDTH-1:0] data,
   output logic             valid,
   output logic             err_out
);
   // data-clock side: hold register and toggle flag
   logic [WIDTH-1:0] hold_q;
   logic             tgl_q;

   always_ff @(posedge dclk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         tgl_q  <= 1'b0;
      end else if (cap) begin
         hold_q <= din;
         tgl_q  <= ~tgl_q;
      end
   end

   // system side: two-stage synchroniser, edge detect, capture
   logic [2:0]       sync_q;
   logic [1:0]       err_sync_q;
   logic [WIDTH-1:0] data_q;
   logic             valid_q;
   logic             pulse;

   assign pulse = sync_q[1] ^ sync_q[2];

   always_ff @(posedge sys_clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q     <= '0;
         err_sync_q <= '0;
         data_q     <= '0;
         valid_q    <= 1'b0;
      end else begin
         sync_q     <= {sync_q[1:0], tgl_q};
         err_sync_q <= {err_sync_q[0], err_in};
         valid_q    <= pulse;
         if (pulse) data_q <= hold_q;
      end
   end

   assign data    = data_q;
   assign valid   = valid_q;
   assign err_out = err_sync_q[1];

   // R8: valid is a single-cycle pulse
   assert_valid_pulse_R8: assert property (@(posedge sys_clk) disable iff (!rst_n)
      valid_q |=> !valid_q);

   // R8: word holds while no valid
   assert_data_hold_R8: assert property (@(posedge sys_clk) disable iff (!rst_n)
      !valid_q |-> $stable(data_q));

   // R7: synchronised error stays set
   assert_err_out_sticky_R7: assert property (@(posedge sys_clk) disable iff (!rst_n)
      err_sync_q[1] |=> err_sync_q[1]);
endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx
   import adc_rx_pkg::*;
#(
   parameter int unsigned LANES     = DEF_LANES,
   parameter int unsigned LANE_BITS = DEF_LANE_BITS
) (
   input  logic                        sys_clk,
   input  logic                        dclk,
   input  logic                        rst_n,
   input  logic                        lane_mode,
   input  logic                        drdy,
   input  logic [LANES-1:0]            dout,
   output logic [LANES*LANE_BITS-1:0]  frame_data,
   output logic                        frame_valid,
   output logic                        frame_err
);
   localparam int unsigned FRAME_BITS = LANES * LANE_BITS;

   if (LANES < 1) begin : g_bad_lanes
      $error("adc_frame_rx: LANES must be at least 1");
   end
   if (LANE_BITS < 2) begin : g_bad_bits
      $error("adc_frame_rx: LANE_BITS must be at least 2");
   end

   lane_mode_e mode;
   logic       wide;
   logic       shift_en;
   logic       last;
   logic       err_d;
   logic [FRAME_BITS-1:0] word_d;

   assign mode = lane_mode_e'(lane_mode);
   assign wide = (mode == LM_WIDE);

   adc_frame_ctrl #(
      .FRAME_BITS (FRAME_BITS),
      .LANE_BITS  (LANE_BITS)
   ) u_ctrl (
      .dclk     (dclk),
      .rst_n    (rst_n),
      .drdy     (drdy),
      .wide     (wide),
      .shift_en (shift_en),
      .last     (last),
      .err      (err_d)
   );

   adc_lane_shifter #(
      .LANES     (LANES),
      .LANE_BITS (LANE_BITS)
   ) u_shift (
      .dclk     (dclk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .wide     (wide),
      .din      (dout),
      .word_d   (word_d)
   );

   adc_frame_cdc #(
      .WIDTH (FRAME_BITS)
   ) u_cdc (
      .dclk    (dclk),
      .sys_clk (sys_clk),
      .rst_n   (rst_n),
      .cap     (last),
      .din     (word_d),
      .err_in  (err_d),
      .data    (frame_data),
      .valid   (frame_valid),
      .err_out (frame_err)
   );
endmodule

// File: tb/adc_frame_rx_tb.sv
module adc_frame_rx_tb;
   localparam int SYS_PERIOD  = 10;
   localparam int DCLK_PERIOD = 26;

   logic        sys_clk = 1'b0;
   logic        dclk    = 1'b0;
   logic        rst_n   = 1'b0;
   logic        lane_mode = 1'b0;
   logic        drdy    = 1'b0;
   logic [2:0]  dout    = '0;
   logic [95:0] frame_data;
   logic        frame_valid;
   logic        frame_err;

   always #(SYS_PERIOD/2)  sys_clk = ~sys_clk;
   always #(DCLK_PERIOD/2) dclk    = ~dclk;

   adc_frame_rx u_dut (
      .sys_clk     (sys_clk),
      .dclk        (dclk),
      .rst_n       (rst_n),
      .lane_mode   (lane_mode),
      .drdy        (drdy),
      .dout        (dout),
      .frame_data  (frame_data),
      .frame_valid (frame_valid),
      .frame_err   (frame_err)
   );

   int          n_run  = 0;
   int          n_fail = 0;
   bit          finished = 0;
   bit          prev_valid = 0;
   logic [95:0] exp_q[$];
   string       tag_q[$];

   task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic put_bit(input logic rdy, input logic [2:0] d);
      @(negedge dclk);
      drdy = rdy;
      dout = d;
   endtask

   // driver: pushes the expected word, then drives the frame
   task automatic send(input logic mode, input logic [95:0] w, input int nbits, input string tag);
      if (nbits < 0) begin
         exp_q.push_back(w);
         tag_q.push_back(tag);
         nbits = mode ? 32 : 96;
      end
      for (int k = 0; k < nbits; k++) begin
         if (mode) put_bit(k == 0, {w[31-k], w[63-k], w[95-k]});
         else      put_bit(k == 0, {2'($urandom), w[95-k]});
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) put_bit(1'b0, 3'($urandom));
   endtask

   task automatic drain(input string req);
      repeat (40) @(negedge sys_clk);
      check(exp_q.size() == 0, req, 96'(exp_q.size()), 96'd0);
   endtask

   // monitor: compares each delivered word with the scoreboard
   always @(negedge sys_clk) begin
      if (rst_n && !finished) begin
         if (frame_valid) begin
            if (prev_valid) check(1'b0, "R8 pulse width", 96'd1, 96'd0);
            if (exp_q.size() == 0) begin
               check(1'b0, "R5 unexpected frame", frame_data, 96'd0);
            end else begin
               logic [95:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(frame_data === e, t, frame_data, e);
            end
         end
         prev_valid = frame_valid;
      end
   end

   initial begin
      #(SYS_PERIOD * 150000);
      if (!finished) begin
         finished = 1;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [95:0] wa, wb, wc, wd, we, wf, wg, wh;
      wa = 96'h123456789ABCDEF0FEDCBA98;
      wb = 96'h800000000000000000000001;
      wc = 96'hA5A5A5A5_3C3C3C3C_0F0F0F0F;
      wd = 96'h01234567_89ABCDEF_F00DCAFE;
      we = 96'hFFFFFFFF_FFFFFFFF_FFFFFFFF;
      wf = 96'h13579BDF_2468ACE0_DEADBEEF;
      wg = 96'h5555AAAA_0000FFFF_C0FFEE11;
      wh = 96'h0F1E2D3C_4B5A6978_8796A5B4;

      // R1: reset state
      repeat (5) @(negedge sys_clk);
      check(frame_valid === 1'b0, "R1 valid", 96'(frame_valid), 96'd0);
      check(frame_err === 1'b0,   "R1 err",   96'(frame_err),   96'd0);
      check(frame_data === '0,    "R1 data",  frame_data,       96'd0);
      rst_n = 1'b1;
      idle(5);

      // R2 / R4 / R9: serial frames with noise on unused lanes
      send(1'b0, wa, -1, "R2 serial word A");
      idle(3);
      send(1'b0, wb, -1, "R9 serial word B, lanes 1-2 noisy");
      drain("R2 all serial frames delivered");
      check(frame_data === wb, "R8 data held after pulse", frame_data, wb);

      // R5: idle noise without strobe
      idle(200);
      drain("R5 idle noise");
      check(frame_data === wb, "R5 data unchanged by idle noise", frame_data, wb);
      check(frame_err === 1'b0, "R5 no error from idle", 96'(frame_err), 96'd0);

      // R3 / R10: wide frames back to back
      lane_mode = 1'b1;
      idle(2);
      send(1'b1, wc, -1, "R3 wide word C");
      send(1'b1, wd, -1, "R10 wide word D back to back");
      idle(2);
      drain("R10 both back-to-back frames delivered");
      check(frame_err === 1'b0, "R10 no error on back-to-back", 96'(frame_err), 96'd0);

      // R6: abort in wide mode
      send(1'b1, we, 10, "");
      send(1'b1, wf, -1, "R6 wide frame after abort");
      idle(2);
      drain("R6 partial wide frame dropped");
      check(frame_err === 1'b1, "R6 error after wide abort", 96'(frame_err), 96'd1);

      // R6: abort in serial mode
      lane_mode = 1'b0;
      idle(2);
      send(1'b0, we, 50, "");
      send(1'b0, wg, -1, "R6 serial frame after abort");
      idle(2);
      drain("R6 partial serial frame dropped");

      // R7: clean frame does not clear the flag
      send(1'b0, wh, -1, "R7 clean frame after error");
      idle(2);
      drain("R7 frame delivered");
      check(frame_err === 1'b1, "R7 error sticky", 96'(frame_err), 96'd1);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule